// File: doc/BRIEF.md
# Programming Cycle Timing Controller

This block times the nonvolatile programming cycle that follows a completed write transaction on a serial memory. Once the bus controller signals that a STOP closed a valid write, the block raises `busy`, drives a program-enable strobe for each byte being written, and on completion drops `busy` and emits a single-cycle `done`. The bus is free for other traffic during the whole cycle, so nothing here depends on the bus after the commit pulse.

Two timing sources exist. In internal mode an oscillator tick passes through a divide-by-`PRESCALE` prescaler, and each byte gets its own sub-period of `INT_TICKS` prescaled ticks, bytes taken one after another. In external mode the cycle length is a fixed count of rising edges on the test pin: `EXT_ONE` edges for one byte and `EXT_TWO` for two. The test pin is synchronised into the system clock domain. Its level is captured on `mode_sample`, which the bus logic pulses at the clock fall of the 8th bit of the address byte: high selects internal timing, low selects external timing.

States: `ST_IDLE` (waiting), `ST_INT_FIRST` (internal, first byte), `ST_INT_SECOND` (internal, second byte), `ST_EXT_RUN` (external counting). Transitions: IDLE→INT_FIRST on commit in internal mode; IDLE→EXT_RUN on commit in external mode; INT_FIRST→INT_SECOND when the sub-period ends and two bytes are latched; INT_FIRST→IDLE when it ends with one byte; INT_SECOND→IDLE when its sub-period ends; EXT_RUN→IDLE on the final counted edge.

Top module: `prog_cycle_ctrl`

## Requirements
- R1: While reset is held, and after it, with no commit, `busy`, `done` and both `prog_en` bits are 0.
- R2: On a `mode_sample` pulse while idle, a synchronised test-pin level of 1 selects internal timing and 0 selects external timing; a `mode_sample` pulse while busy changes nothing.
- R3: `busy` is 1 in the cycle after a `commit` pulse taken while idle; a `commit` while busy neither restarts nor extends the cycle.
- R4: In internal mode with `osc_tick` high every cycle, each byte lasts `INT_TICKS`×`PRESCALE` cycles; `prog_en[0]` (first byte) is high for the first sub-period and `prog_en[1]` (second byte) for the second, so two bytes take twice as long as one.
- R5: The prescaler advances only in cycles with `osc_tick` high; with `osc_tick` high every other cycle a one-byte internal cycle lasts twice as long (within one cycle).
- R6: In external mode the cycle ends on the `EXT_ONE`-th (default 257) test-pin rising edge for one byte and the `EXT_TWO`-th (default 513) for two; `prog_en[0]` is high for the whole cycle and `prog_en[1]` too when two bytes are latched.
- R7: Test-pin rising edges seen while idle are not counted toward an external cycle.
- R8: `done` is a single-cycle pulse in the first cycle in which `busy` is 0 after a cycle.
- R9: `two_bytes` is latched at the commit (0 = one byte, 1 = two bytes); changes to it during the cycle have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sample | input | 1 | Strobe capturing the test-pin level as timing mode |
| test_pin | input | 1 | Asynchronous test pin: mode level and external timing clock |
| two_bytes | input | 1 | Byte count of the write: 0 one byte, 1 two bytes |
| commit | input | 1 | Pulse: STOP ended a complete write sequence |
| osc_tick | input | 1 | Internal oscillator tick, one cycle wide |
| busy | output | 1 | Programming cycle in progress |
| prog_en | output | 2 | Per-byte program enable, bit 0 first byte |
| done | output | 1 | One-cycle pulse at the end of a cycle |

## Verification
Two functions can meet in one cycle: a new `commit` or `mode_sample` arriving while a cycle is running, and the end-of-cycle decision. The bench provokes this by pulsing both during an internal cycle with the test pin pulled low, so a wrongly accepted mode switch would make the cycle wait for edges that never come. It is judged by the measured busy length being exactly the one-byte value, one `done` pulse, and `busy` staying low afterwards.

// File: rtl/prog_cycle_pkg.sv
package prog_cycle_pkg;
    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_INT_FIRST  = 2'd1,
        ST_INT_SECOND = 2'd2,
        ST_EXT_RUN    = 2'd3
    } pc_state_t;
endpackage

// File: rtl/pc_edge_sync.sv
module pc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level_o,
    output logic rise_o
);
    logic [STAGES:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-1:0], async_in};
    end

    assign level_o = chain_q[STAGES-1];
    assign rise_o  = chain_q[STAGES-1] & ~chain_q[STAGES];

    // a detected rise needs a low sample before it can repeat
    assert_rise_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/pc_prescaler.sv
module pc_prescaler #(
    parameter int DIV = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick_in,
    output logic tick_out
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    assign tick_out = tick_in && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt_q <= '0;
        else if (clear)   cnt_q <= '0;
        else if (tick_in) cnt_q <= tick_out ? '0 : cnt_q + 1'b1;
    end

    assert_prescale_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_out && (DIV > 1)) |=> !tick_out);
endmodule

// File: rtl/pc_span_counter.sv
module pc_span_counter #(
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          step,
    input  logic [CW-1:0] target,
    output logic          hit
);
    logic [CW-1:0] cnt_q;

    assign hit = step && (cnt_q == target - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt_q <= '0;
        else if (clear) cnt_q <= '0;
        else if (step)  cnt_q <= hit ? '0 : cnt_q + 1'b1;
    end

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |-> (cnt_q < target));
endmodule

// File: rtl/prog_cycle_ctrl.sv
module prog_cycle_ctrl
    import prog_cycle_pkg::*;
#(
    parameter int PRESCALE  = 128,
    parameter int INT_TICKS = 4,
    parameter int EXT_ONE   = 257,
    parameter int EXT_TWO   = 513,
    parameter int SYNC_FF   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_sample,
    input  logic       test_pin,
    input  logic       two_bytes,
    input  logic       commit,
    input  logic       osc_tick,
    output logic       busy,
    output logic [1:0] prog_en,
    output logic       done
);
    localparam int MAXC = (EXT_TWO > INT_TICKS) ? EXT_TWO : INT_TICKS;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] T_INT = CW'(INT_TICKS);
    localparam logic [CW-1:0] T_E1  = CW'(EXT_ONE);
    localparam logic [CW-1:0] T_E2  = CW'(EXT_TWO);

    pc_state_t state_q, state_d;
    logic ext_q, two_q, done_q;
    logic test_level, test_rise, pre_tick, span_hit, span_step, in_int;
    logic [CW-1:0] span_target;

    pc_edge_sync #(.STAGES(SYNC_FF)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(test_pin),
        .level_o(test_level), .rise_o(test_rise)
    );

    assign in_int = (state_q == ST_INT_FIRST) || (state_q == ST_INT_SECOND);

    pc_prescaler #(.DIV(PRESCALE)) u_pre (
        .clk(clk), .rst_n(rst_n), .clear(!in_int),
        .tick_in(osc_tick), .tick_out(pre_tick)
    );

    assign span_step   = (in_int && pre_tick) || ((state_q == ST_EXT_RUN) && test_rise);
    assign span_target = (state_q == ST_EXT_RUN) ? (two_q ? T_E2 : T_E1) : T_INT;

    pc_span_counter #(.CW(CW)) u_span (
        .clk(clk), .rst_n(rst_n), .clear(state_q == ST_IDLE),
        .step(span_step), .target(span_target), .hit(span_hit)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (commit)   state_d = ext_q ? ST_EXT_RUN : ST_INT_FIRST;
            ST_INT_FIRST:  if (span_hit) state_d = two_q ? ST_INT_SECOND : ST_IDLE;
            ST_INT_SECOND: if (span_hit) state_d = ST_IDLE;
            ST_EXT_RUN:    if (span_hit) state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    // state register and latches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ext_q   <= 1'b0;
            two_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q != ST_IDLE) && (state_d == ST_IDLE);
            if (state_q == ST_IDLE && mode_sample) ext_q <= ~test_level;
            if (state_q == ST_IDLE && commit)      two_q <= two_bytes;
        end
    end

    // outputs
    always_comb begin
        busy    = 1'b1;
        prog_en = 2'b00;
        unique case (state_q)
            ST_IDLE:       busy    = 1'b0;
            ST_INT_FIRST:  prog_en = 2'b01;
            ST_INT_SECOND: prog_en = 2'b10;
            ST_EXT_RUN:    prog_en = {two_q, 1'b1};
            default:       busy    = 1'b0;
        endcase
    end
    assign done = done_q;

    assert_busy_after_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !busy) |=> busy);
    assert_done_at_busy_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_en_only_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (prog_en == 2'b00));
    assert_int_one_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
        in_int |-> ($countones(prog_en) == 1));
    assert_mode_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(ext_q));
    assert_count_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(two_q));
endmodule

// File: tb/prog_cycle_ctrl_test.sv
module prog_cycle_ctrl_test;
    localparam int PRESCALE  = 128;
    localparam int INT_TICKS = 4;
    localparam int PER_BYTE  = PRESCALE * INT_TICKS;

    logic clk = 1'b0, rst_n = 1'b0;
    logic mode_sample = 0, test_pin = 1, two_bytes = 0, commit = 0, osc_half = 0;
    logic osc_tick, busy, done;
    logic [1:0] prog_en;
    int cyc = 0;
    int n_busy = 0, n_en0 = 0, n_en1 = 0, n_done = 0, n_bad = 0;
    logic done_prev = 0;
    int errors = 0, checks = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;
    always @(negedge clk) cyc <= cyc + 1;
    assign osc_tick = osc_half ? cyc[0] : 1'b1;

    prog_cycle_ctrl #(.PRESCALE(PRESCALE), .INT_TICKS(INT_TICKS)) uut (
        .clk(clk), .rst_n(rst_n), .mode_sample(mode_sample), .test_pin(test_pin),
        .two_bytes(two_bytes), .commit(commit), .osc_tick(osc_tick),
        .busy(busy), .prog_en(prog_en), .done(done)
    );

    always @(negedge clk) if (rst_n) begin
        if (busy)       n_busy++;
        if (prog_en[0]) n_en0++;
        if (prog_en[1]) n_en1++;
        if (done)       n_done++;
        if (done && (busy || done_prev)) n_bad++;
        done_prev = done;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic set_mode(input logic lvl);
        @(negedge clk) test_pin = lvl;
        repeat (4) @(negedge clk);
        mode_sample = 1;
        @(negedge clk) mode_sample = 0;
    endtask

    task automatic do_commit(input logic two);
        @(negedge clk) begin two_bytes = two; commit = 1; end
        @(negedge clk) commit = 0;
        check(busy === 1'b1, "R3", "busy cycle after commit", busy, 1);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) test_pin = 1;
            repeat (3) @(negedge clk);
            test_pin = 0;
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check(busy == 0 && done == 0 && prog_en == 0, "R1", "outputs in reset",
              {busy, done, prog_en}, 0);
        rst_n = 1;
        repeat (5) @(negedge clk);
        check(busy == 0 && done == 0 && prog_en == 0, "R1", "outputs after reset",
              {busy, done, prog_en}, 0);
    endtask

    task automatic t_internal(input logic two, input int exp_len);
        int b0 = n_busy, e0 = n_en0, e1 = n_en1, d0 = n_done;
        set_mode(1'b1);
        do_commit(two);
        two_bytes = ~two;   // R9: must not matter
        wait_idle();
        check(n_busy - b0 == exp_len, "R4", "internal busy length", n_busy - b0, exp_len);
        check(n_en0 - e0 == PER_BYTE, "R4", "first byte enable length", n_en0 - e0, PER_BYTE);
        check(n_en1 - e1 == (two ? PER_BYTE : 0), "R9", "second byte enable length",
              n_en1 - e1, two ? PER_BYTE : 0);
        check(n_done - d0 == 1, "R8", "done pulses", n_done - d0, 1);
    endtask

    task automatic t_half_rate();
        int b0 = n_busy;
        osc_half = 1;
        set_mode(1'b1);
        do_commit(1'b0);
        wait_idle();
        osc_half = 0;
        check((n_busy - b0 >= 2 * PER_BYTE - 1) && (n_busy - b0 <= 2 * PER_BYTE), "R5",
              "half-rate tick busy length", n_busy - b0, 2 * PER_BYTE);
    endtask

    task automatic t_external(input logic two);
        int need = two ? 513 : 257;
        int b0, e0, e1, d0;
        set_mode(1'b0);
        check(busy == 0, "R2", "no start on mode sample", busy, 0);
        pulses(10);   // R7: idle edges not counted
        repeat (4) @(negedge clk);
        b0 = n_busy; e0 = n_en0; e1 = n_en1; d0 = n_done;
        do_commit(two);
        two_bytes = ~two;
        pulses(need - 1);
        repeat (2) @(negedge clk);
        check(busy == 1 && n_done == d0, "R7", "still busy one edge short", busy, 1);
        check(prog_en == {two, 1'b1}, "R6", "external enables", prog_en, {two, 1'b1});
        pulses(1);
        @(negedge clk);
        check(busy == 0, "R6", "idle after final edge", busy, 0);
        check(n_done - d0 == 1, "R8", "one done pulse external", n_done - d0, 1);
        check(n_en0 - e0 == n_busy - b0, "R6", "first enable whole cycle",
              n_en0 - e0, n_busy - b0);
        check(n_en1 - e1 == (two ? n_busy - b0 : 0), "R9", "second enable whole cycle",
              n_en1 - e1, two ? n_busy - b0 : 0);
    endtask

    task automatic t_overlap();
        int b0, d0;
        set_mode(1'b1);
        b0 = n_busy; d0 = n_done;
        do_commit(1'b0);
        repeat (100) @(negedge clk);
        test_pin = 0;
        repeat (4) @(negedge clk);
        mode_sample = 1; commit = 1;
        @(negedge clk) begin mode_sample = 0; commit = 0; end
        wait_idle();
        check(n_busy - b0 == PER_BYTE, "R2", "mode sample while busy ignored",
              n_busy - b0, PER_BYTE);
        repeat (20) @(negedge clk);
        check(busy == 0 && n_done - d0 == 1, "R3", "commit while busy ignored",
              n_done - d0, 1);
    endtask

    initial begin
        t_reset();
        t_internal(1'b0, PER_BYTE);
        t_internal(1'b1, 2 * PER_BYTE);
        t_half_rate();
        t_external(1'b0);
        t_external(1'b1);
        t_overlap();
        check(n_bad == 0, "R8", "done overlapped busy or lasted >1 cycle", n_bad, 0);
        finished = 1;
        report();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            report();
        end
    end
endmodule